// File: doc/BRIEF.md
# Parallel Display Bus Timing Engine

This block is the master side of an 8080-style parallel bus that feeds an external display controller with its own frame memory. Every access is a bus cycle measured in ticks. A tick is one or two clocks of the interface clock. Programmed tick counts place each edge of chip-select, write strobe and read strobe inside the cycle on its own, and separate counts set how long write and read cycles last.

A host port with a ready/valid handshake carries several operations: command writes, data writes, read triggers, and configuration writes for the timing words, the mode, the pixel count and the stream control. A read trigger runs one read cycle. The sampled bus word then appears on `readData` when that cycle ends.

In streaming mode the same sequencer takes pixels from a ready/valid input stream. It runs one data write cycle per pixel until the programmed count is used up, then pulses `frameDone`. Clearing the enable bit stops the stream before the count is reached.

Top module: `lcd_bus_engine`

## Requirements
- R1: Reset state. After reset `csN`, `weN` and `reN` are high, `rsOut` is high, `busOe` is low, `busy` is low, `readData` is zero and `hostReady` is high. Once the bus has been idle for two clocks, all three strobes are high and `busOe` is low.
- R2: Register-select line.
  - `rsOut` is low for command cycles (hostOp 0).
  - `rsOut` is high for data cycles (hostOp 1), read cycles (hostOp 2) and pixel cycles.
  - `rsOut` does not change while a cycle is in progress.
- R3: `busOe` is high only inside write cycles. It is never high while `reN` is low.
- R4: Mode word (hostOp 5). Bits 1:0 give the tick divider, and only the values 1 and 2 are accepted. Bit 4 selects the 16-bit bus when 1 and the 8-bit bus when 0. A mode word with any other divider value is ignored as a whole, so both the divider and the width stay as they were. The reset mode is divider 1 with a 16-bit bus.
- R5: Edge timing word (hostOp 3). The fields are:
  - chip-select on at bits 3:0 and off at 9:4;
  - write-strobe on at 13:10 and off at 19:14;
  - read-strobe on at 23:20 and off at 29:24.
  
  `weN` stays low for (WE-off − WE-on) ticks and `reN` for (RE-off − RE-on) ticks. The reset values are CS 0/3, WE 1/2 and RE 1/2.
- R6: Cycle word (hostOp 4). It holds the write cycle length at bits 5:0, the read cycle length at bits 11:6 and the access tick at bits 27:22. Bits 17:12 are ignored. `busy` stays high for exactly (cycle length × divider) clocks. The reset values are write 3, read 3 and access 2.
- R7: Each accepted command or data word produces exactly one write cycle. The bus carries the low 16 bits of `hostData`, or in 8-bit mode the low byte with bits 15:8 at zero.
- R8: Read cycles (hostOp 2).
  - `busIn` is sampled in the first clock of the access tick.
  - `readData` keeps its old value while the read cycle runs and takes the new sample when the cycle ends.
  - In 8-bit mode `readData` is zero-extended.
- R9: While a cycle is in progress or a stream is armed, `hostReady` is low for every operation except stream control (hostOp 7). Stream control is always ready.
- R10: Streaming.
  - A pixel-count word (hostOp 6) sets the count.
  - A stream-control word (hostOp 7) with enable (bit 0) and internal trigger (bit 1) both set starts the stream.
  - The block then runs exactly that many write cycles with `rsOut` high, one pixel each.
  - `frameDone` pulses for one clock in the clock after the last cycle ends.
- R11: A stream-control word with bit 0 clear stops the stream. No further pixel is taken and no `frameDone` pulse follows.
- R12: Starting a stream with a pixel count of zero runs no bus cycle and gives a `frameDone` pulse at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host operation valid |
| hostReady | output | 1 | Host operation accepted when high with valid |
| hostOp | input | 3 | Operation: 0 cmd, 1 data, 2 read, 3 edge timing, 4 cycle, 5 mode, 6 pixel count, 7 stream control |
| hostData | input | 32 | Operation payload |
| pixValid | input | 1 | Pixel stream valid |
| pixReady | output | 1 | Pixel taken when high with valid |
| pixData | input | 16 | Pixel word |
| csN | output | 1 | Chip select, active low |
| weN | output | 1 | Write strobe, active low |
| reN | output | 1 | Read strobe, active low |
| rsOut | output | 1 | Command (low) versus data (high) select |
| busOut | output | 16 | Data bus drive value |
| busOe | output | 1 | Data bus output enable |
| busIn | input | 16 | Data bus input value |
| readData | output | 16 | Result of the last completed read |
| busy | output | 1 | A bus cycle is in progress |
| frameDone | output | 1 | One-clock pulse at the end of a stream |

## Verification
A cycle starts on the clock edge that accepts an operation or a pixel, and `busy` rises at that edge. The bus pins follow the tick decode one clock later. As a result, each strobe stays low for the programmed number of ticks times the divider, while `busy` stays high for the cycle length times the divider. `readData` changes on the edge at which `busy` falls, and `frameDone` comes one clock after that final falling edge.

The bench samples all outputs on falling clock edges. Its monitor measures strobe widths by counting low samples, and it compares the data on the bus against its scoreboard at each rising edge of the write strobe. The driver counts the busy clocks itself and reads `readData` only after `busy` has fallen, so none of these checks depends on guessing a fixed latency.

// File: rtl/lbe_pkg.sv
package lbe_pkg;

  typedef enum logic [2:0] {
    OP_CMD     = 3'd0,
    OP_DATA    = 3'd1,
    OP_READ    = 3'd2,
    OP_TIMING  = 3'd3,
    OP_CYCLE   = 3'd4,
    OP_MODE    = 3'd5,
    OP_PIXCNT  = 3'd6,
    OP_CONTROL = 3'd7
  } hostOp_e;

  // strobes from the sequencer to the pin datapath
  typedef struct packed {
    logic csAct;
    logic weAct;
    logic reAct;
    logic oeAct;
    logic load;
    logic sample;
    logic publish;
  } busStrobe_t;

  typedef struct packed {
    logic [3:0] csOn;
    logic [5:0] csOff;
    logic [3:0] weOn;
    logic [5:0] weOff;
    logic [3:0] reOn;
    logic [5:0] reOff;
    logic [5:0] weCyc;
    logic [5:0] reCyc;
    logic [5:0] accT;
  } busTiming_t;

  localparam busTiming_t TIMING_RST = '{
    csOn: 4'd0, csOff: 6'd3, weOn: 4'd1, weOff: 6'd2,
    reOn: 4'd1, reOff: 6'd2, weCyc: 6'd3, reCyc: 6'd3, accT: 6'd2};

endpackage

// File: rtl/lbe_ticker.sv
module lbe_ticker (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  input  logic div2,
  output logic tickEn,
  output logic firstPhase
);

  logic presc;

  always_ff @(posedge clk) begin
    if (!rstN)                presc <= 1'b0;
    else if (restart || !div2) presc <= 1'b0;
    else                      presc <= ~presc;
  end

  assign tickEn     = !div2 || presc;
  assign firstPhase = !presc;

  // R4: with divide-by-two no two consecutive clocks both end a tick
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (div2 && $past(div2) && $past(tickEn)) |-> !tickEn);

endmodule

// File: rtl/lbe_ctrl.sv
module lbe_ctrl
  import lbe_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostValid,
  output logic             hostReady,
  input  logic [2:0]       hostOp,
  input  logic [31:0]      hostData,
  input  logic             pixValid,
  output logic             pixReady,
  input  logic [15:0]      pixData,
  input  logic             tickEn,
  input  logic             firstPhase,
  output logic             restart,
  output busStrobe_t       stb,
  output logic [15:0]      word,
  output logic             rsLine,
  output logic             width16,
  output logic             div2,
  output logic             busy,
  output logic             frameDone
);

  localparam int TCNT_W = 6;

  busTiming_t          tim;
  logic                active, isRead, curRs, streamOn;
  logic [TCNT_W-1:0]   tcnt;
  logic [TCNT_W:0]     tNext;
  logic [TCNT_W-1:0]   cycLen;
  logic [CNT_W-1:0]    pixTotal, pixLeft;
  logic                isCtl, idle, hostFire, hostBus, pixFire, start, endNow;
  logic                unusedHostBits;

  assign unusedHostBits = ^{hostData[31:30], hostData[21:18], hostData[3:2], hostData[5]};

  assign isCtl     = (hostOp == OP_CONTROL);
  assign idle      = !active && !streamOn;
  assign hostReady = isCtl || idle;
  assign hostFire  = hostValid && hostReady;
  assign hostBus   = hostFire && (hostOp == OP_CMD || hostOp == OP_DATA || hostOp == OP_READ);
  assign pixReady  = streamOn && !active && (pixLeft != '0);
  assign pixFire   = pixReady && pixValid;
  assign start     = pixFire || hostBus;
  assign restart   = start;

  assign cycLen = isRead ? tim.reCyc : tim.weCyc;
  assign tNext  = {1'b0, tcnt} + 7'd1;
  assign endNow = active && tickEn && (tNext >= {1'b0, cycLen});

  // tick-window decode of every strobe
  always_comb begin
    stb.csAct   = active && (tcnt >= {2'b0, tim.csOn}) && (tcnt < tim.csOff);
    stb.weAct   = active && !isRead && (tcnt >= {2'b0, tim.weOn}) && (tcnt < tim.weOff);
    stb.reAct   = active && isRead && (tcnt >= {2'b0, tim.reOn}) && (tcnt < tim.reOff);
    stb.oeAct   = active && !isRead;
    stb.load    = start;
    stb.sample  = active && isRead && (tcnt == tim.accT) && firstPhase;
    stb.publish = endNow && isRead;
  end

  assign word   = pixFire ? pixData : hostData[15:0];
  assign rsLine = curRs;
  assign busy   = active;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      isRead    <= 1'b0;
      curRs     <= 1'b1;
      tcnt      <= '0;
      tim       <= TIMING_RST;
      div2      <= 1'b0;
      width16   <= 1'b1;
      pixTotal  <= '0;
      pixLeft   <= '0;
      streamOn  <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;

      if (start) begin
        active <= 1'b1;
        tcnt   <= '0;
        isRead <= !pixFire && (hostOp == OP_READ);
        curRs  <= pixFire || (hostOp != OP_CMD);
      end else if (endNow) begin
        active <= 1'b0;
      end else if (active && tickEn) begin
        tcnt <= tNext[TCNT_W-1:0];
      end

      if (pixFire) pixLeft <= pixLeft - 1'b1;

      if (streamOn && (pixLeft == '0) && !active && !(hostFire && isCtl)) begin
        streamOn  <= 1'b0;
        frameDone <= 1'b1;
      end

      if (hostFire) begin
        unique case (hostOp)
          OP_TIMING: begin
            tim.csOn  <= hostData[3:0];
            tim.csOff <= hostData[9:4];
            tim.weOn  <= hostData[13:10];
            tim.weOff <= hostData[19:14];
            tim.reOn  <= hostData[23:20];
            tim.reOff <= hostData[29:24];
          end
          OP_CYCLE: begin
            tim.weCyc <= hostData[5:0];
            tim.reCyc <= hostData[11:6];
            tim.accT  <= hostData[27:22];
          end
          OP_MODE: begin
            if (hostData[1:0] == 2'd1 || hostData[1:0] == 2'd2) begin
              div2    <= (hostData[1:0] == 2'd2);
              width16 <= hostData[4];
            end
          end
          OP_PIXCNT: pixTotal <= hostData[CNT_W-1:0];
          OP_CONTROL: begin
            if (!hostData[0]) begin
              streamOn <= 1'b0;
            end else if (hostData[1]) begin
              streamOn <= 1'b1;
              pixLeft  <= pixTotal;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: select line constant while one cycle runs
  a_r2_rs_stable: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active)) |-> $stable(curRs));

  // R10: done pulse only once the sequencer and stream are quiet
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (!active && !streamOn));

  // R9: no bus-starting operation is accepted mid-cycle
  a_r9_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    (active && hostValid && hostReady) |=> $stable(isRead));

endmodule

// File: rtl/lbe_datapath.sv
module lbe_datapath
  import lbe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  busStrobe_t  stb,
  input  logic [15:0] word,
  input  logic        width16,
  input  logic        rsLine,
  input  logic [15:0] busIn,
  output logic        csN,
  output logic        weN,
  output logic        reN,
  output logic        rsOut,
  output logic [15:0] busOut,
  output logic        busOe,
  output logic [15:0] readData
);

  logic [15:0] wordReg, capReg, inWord;

  assign inWord = width16 ? busIn : {8'h00, busIn[7:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN      <= 1'b1;
      weN      <= 1'b1;
      reN      <= 1'b1;
      rsOut    <= 1'b1;
      busOe    <= 1'b0;
      busOut   <= '0;
      wordReg  <= '0;
      capReg   <= '0;
      readData <= '0;
    end else begin
      csN    <= !stb.csAct;
      weN    <= !stb.weAct;
      reN    <= !stb.reAct;
      busOe  <= stb.oeAct;
      rsOut  <= rsLine;
      busOut <= width16 ? wordReg : {8'h00, wordReg[7:0]};
      if (stb.load)    wordReg  <= word;
      if (stb.sample)  capReg   <= inWord;
      if (stb.publish) readData <= stb.sample ? inWord : capReg;
    end
  end

  // R3: never drive the bus while the read strobe is low
  a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> !busOe);

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
  import lbe_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostValid,
  output logic        hostReady,
  input  logic [2:0]  hostOp,
  input  logic [31:0] hostData,
  input  logic        pixValid,
  output logic        pixReady,
  input  logic [15:0] pixData,
  output logic        csN,
  output logic        weN,
  output logic        reN,
  output logic        rsOut,
  output logic [15:0] busOut,
  output logic        busOe,
  input  logic [15:0] busIn,
  output logic [15:0] readData,
  output logic        busy,
  output logic        frameDone
);

  busStrobe_t  stb;
  logic [15:0] word;
  logic        rsLine, width16, div2, tickEn, firstPhase, restart;

  lbe_ticker ticker_i (
    .clk(clk), .rstN(rstN), .restart(restart), .div2(div2),
    .tickEn(tickEn), .firstPhase(firstPhase));

  lbe_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
    .hostOp(hostOp), .hostData(hostData), .pixValid(pixValid),
    .pixReady(pixReady), .pixData(pixData), .tickEn(tickEn),
    .firstPhase(firstPhase), .restart(restart), .stb(stb), .word(word),
    .rsLine(rsLine), .width16(width16), .div2(div2), .busy(busy),
    .frameDone(frameDone));

  lbe_datapath datapath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .word(word), .width16(width16),
    .rsLine(rsLine), .busIn(busIn), .csN(csN), .weN(weN), .reN(reN),
    .rsOut(rsOut), .busOut(busOut), .busOe(busOe), .readData(readData));

  // R1: two idle clocks leave every strobe released and the bus undriven
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> (csN && weN && reN && !busOe));

endmodule

// File: tb/lcd_bus_engine_tb_top.sv
module lcd_bus_engine_tb_top;
  import lbe_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0;
  logic [2:0]  hostOp = 3'd0;
  logic [31:0] hostData = '0;
  logic        pixValid = 1'b0;
  logic [15:0] pixData = '0;
  logic [15:0] busIn = '0;
  logic        hostReady, pixReady, csN, weN, reN, rsOut, busOe, busy, frameDone;
  logic [15:0] busOut, readData;

  always #5 clk = ~clk;

  lcd_bus_engine dut_i (.*);

  int nChecks = 0, nBad = 0;
  int expWeLow = 1, expReLow = 1;
  int nWrites = 0, doneCnt = 0, writesAtDone = 0;
  logic [16:0] expQ[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic doHost(input logic [2:0] op, input logic [31:0] d);
    @(negedge clk);
    hostOp = op; hostData = d; hostValid = 1'b1;
    #1;
    while (!hostReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    hostValid = 1'b0;
  endtask

  task automatic busyLen(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (busy) n++; else break;
    end
  endtask

  task automatic writeWord(input logic [2:0] op, input logic [15:0] d,
                           input logic [15:0] expBus, input int expBusy, input string tag);
    int n;
    expQ.push_back({op != 3'd0, expBus});
    doHost(op, {16'h0, d});
    busyLen(n);
    chk(n == expBusy, {tag, " busy length"}, n, expBusy);
    repeat (3) @(negedge clk);
  endtask

  task automatic readWord(input logic [15:0] drive, input logic [15:0] exp,
                          input int expBusy, input string tag);
    int n;
    logic [15:0] old;
    bit heldOld;
    old = readData; heldOld = 1'b1;
    busIn = drive;
    doHost(3'd2, 32'h0);
    n = 0;
    forever begin
      @(negedge clk);
      if (busy) begin n++; if (readData !== old) heldOld = 1'b0; end
      else break;
    end
    chk(heldOld, {tag, " R8 readData held during cycle"}, 0, 0);
    chk(readData == exp, {tag, " R8 readData"}, readData, exp);
    chk(n == expBusy, {tag, " R6 read busy length"}, n, expBusy);
    repeat (3) @(negedge clk);
  endtask

  task automatic feedPixels(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pixData = base + 16'(i); pixValid = 1'b1;
      expQ.push_back({1'b1, base + 16'(i)});
      #1;
      while (!pixReady) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      pixValid = 1'b0;
    end
  endtask

  // monitor: strobe widths and scoreboard compare at write-strobe release
  int weLen = 0, reLen = 0;
  logic [15:0] capBus;
  logic capRs, capOe, oeOnRead, rsOnRead;
  logic [16:0] item;
  always @(negedge clk) begin
    if (rstN) begin
      if (!weN) begin
        weLen++; capBus = busOut; capRs = rsOut; capOe = busOe;
      end else if (weLen > 0) begin
        nWrites++;
        chk(weLen == expWeLow, "R5 write strobe width", weLen, expWeLow);
        chk(capOe, "R3 bus driven in write", capOe, 1);
        if (expQ.size() == 0) chk(1'b0, "R7 unexpected write cycle", capBus, 0);
        else begin
          item = expQ.pop_front();
          chk(capBus == item[15:0], "R7 write data", capBus, item[15:0]);
          chk(capRs == item[16], "R2 select line", capRs, item[16]);
        end
        weLen = 0;
      end
      if (!reN) begin
        if (reLen == 0) begin oeOnRead = 1'b0; rsOnRead = 1'b1; end
        reLen++;
        if (busOe) oeOnRead = 1'b1;
        if (!rsOut) rsOnRead = 1'b0;
      end else if (reLen > 0) begin
        chk(reLen == expReLow, "R5 read strobe width", reLen, expReLow);
        chk(!oeOnRead, "R3 no drive during read", oeOnRead, 0);
        chk(rsOnRead, "R2 select high on read", rsOnRead, 1);
        reLen = 0;
      end
      if (frameDone) begin doneCnt++; writesAtDone = nWrites; end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    int w0, d0;
    bit sawReady;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(csN && weN && reN && rsOut, "R1 strobes and select idle", {csN, weN, reN, rsOut}, 4'hf);
    chk(!busOe && !busy, "R1 bus released, not busy", {busOe, busy}, 0);
    chk(readData == 16'h0, "R1 readData zero", readData, 0);
    chk(hostReady, "R1 hostReady", hostReady, 1);

    // defaults: WE 1..2, write cycle 3, divider 1, 16-bit
    expWeLow = 1;
    writeWord(3'd0, 16'hA5C3, 16'hA5C3, 3, "R7 cmd default timing R6");

    // program edges and cycles, R5 field positions, R6 ignored bits 17:12
    doHost(3'd3, 32'(1 | (7 << 4) | (2 << 10) | (5 << 14) | (1 << 20) | (6 << 24)));
    doHost(3'd4, 32'(7 | (8 << 6) | (5 << 12) | (4 << 22)));
    expWeLow = 3; expReLow = 5;
    expQ.push_back({1'b1, 16'h1234});
    doHost(3'd1, 32'h0000_1234);
    // R9 hold-off while busy
    hostOp = 3'd0; #1;
    chk(!hostReady, "R9 cmd held off while busy", hostReady, 0);
    hostOp = 3'd7; #1;
    chk(hostReady, "R9 control always ready", hostReady, 1);
    busyLen(w0);
    chk(w0 == 7, "R6 programmed write cycle", w0, 7);
    repeat (3) @(negedge clk);

    readWord(16'hBEEF, 16'hBEEF, 8, "16-bit read");

    // R4 divide by two, 8-bit bus
    doHost(3'd5, 32'h0000_0002);
    expWeLow = 6; expReLow = 10;
    writeWord(3'd1, 16'hAB77, 16'h0077, 14, "R4 R7 8-bit div2");
    readWord(16'h3C5A, 16'h005A, 16, "R8 8-bit zero-extend");

    // R4 divider 3 rejected: width and divider unchanged
    doHost(3'd5, 32'h0000_0013);
    writeWord(3'd1, 16'h9911, 16'h0011, 14, "R4 rejected mode word");

    // back to divider 1, 16-bit
    doHost(3'd5, 32'h0000_0011);
    expWeLow = 3; expReLow = 5;

    // R10 stream of 5 pixels
    d0 = doneCnt; w0 = nWrites;
    doHost(3'd6, 32'd5);
    doHost(3'd7, 32'h3);
    hostOp = 3'd1; #1;
    chk(!hostReady, "R9 data held off while streaming", hostReady, 0);
    feedPixels(5, 16'h0100);
    for (int i = 0; i < 200 && doneCnt == d0; i++) @(negedge clk);
    chk(doneCnt == d0 + 1, "R10 one done pulse", doneCnt - d0, 1);
    chk(writesAtDone - w0 == 5, "R10 pixel cycles before done", writesAtDone - w0, 5);
    chk(expQ.size() == 0, "R10 all pixels on bus", expQ.size(), 0);

    // R11 stop after 3 of 20
    d0 = doneCnt; w0 = nWrites;
    doHost(3'd6, 32'd20);
    doHost(3'd7, 32'h3);
    feedPixels(3, 16'h0200);
    repeat (20) @(negedge clk);
    doHost(3'd7, 32'h0);
    sawReady = 1'b0;
    @(negedge clk);
    pixValid = 1'b1; pixData = 16'hDEAD;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pixReady) sawReady = 1'b1; end
    pixValid = 1'b0;
    repeat (10) @(negedge clk);
    chk(!sawReady, "R11 no pixel taken after stop", sawReady, 0);
    chk(nWrites - w0 == 3, "R11 cycles before stop", nWrites - w0, 3);
    chk(doneCnt == d0, "R11 no done after stop", doneCnt - d0, 0);
    chk(hostReady, "R11 host port free after stop", hostReady, 1);

    // R12 zero count
    d0 = doneCnt; w0 = nWrites;
    doHost(3'd6, 32'd0);
    doHost(3'd7, 32'h3);
    repeat (5) @(negedge clk);
    chk(doneCnt == d0 + 1, "R12 done on zero count", doneCnt - d0, 1);
    chk(nWrites == w0, "R12 no cycle on zero count", nWrites - w0, 0);
    chk(!busOe && csN, "R1 idle after all traffic", {busOe, csN}, 1);

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule